// File: doc/BRIEF.md
# System Control Register Block

This block is the control and status register file of a small two-core microcontroller subsystem. Software reaches it through a 32-bit APB slave port that spans a 4 KB window. It keeps a debug-permission status word, which software changes only through a bit-set alias and a bit-clear alias. It also holds a reset-cause word, a reset mask, a retention word that survives warm resets, a per-core initial vector base and a per-core hold-in-wait register. Its outputs are a one-cycle system reset request, one-cycle per-core release pulses and the per-core vector values.

A version strap input chooses between a base variant and an extended variant. The extended variant is active when the top nibble of the strap equals a parameterised code, 2 by default. It adds a security control word, two clock-divider words, a clock-force word, the second core's vector base, a second wake control word and five power-sense words. These extra words only store what software writes; they act on nothing.

The port has no back-pressure. Every transfer finishes in its access phase with no wait states and an OKAY response. Because the port never refuses a transfer, protocol misuse is reported on a separate one-cycle error flag.

Top module: `sysctl_regs`

## Requirements
- R1: Every transfer completes in its access phase: `pready` is 1 and `pslverr` is 0 whenever `psel` and `penable` are high.
- R2: After reset, the reset-cause word (0x100) reads 1, the system power-sense word (0x200, extended variant) reads 0x7F, both vector bases read the parameter `VEC_RST` (default 0x1000_0000), the hold word (0x118) reads `HOLD_RST` (default 0), and every other word reads 0.
- R3: A write to 0x004 ORs the written data into the debug status word at 0x000. A write to 0x008 clears every status bit that is written as 1. Software cannot write 0x000 directly.
- R4: A write to 0x108 with bit 9 set raises `sw_reset_req` for exactly the cycle after the write. A write with bit 9 clear raises nothing. Reads of 0x108 return 0.
- R5: The hold word at 0x118 stores the full written value. Bit 0 belongs to core 0 and bit 1 to core 1. When a write changes one of these bits from 1 to 0, the matching `core_release` bit pulses for the one cycle after the write.
- R6: The vector base at 0x110 (core 0) is readable and drives `core_vector[31:0]`. The vector base at 0x114 (core 1) is readable and drives `core_vector[63:32]`.
- R7: The extended variant is active when `ver_strap[31:28]` equals 2. In it, the words at 0x00C, 0x010, 0x014, 0x018, 0x114, 0x11C, 0x124, 0x200, 0x20C, 0x210, 0x214 and 0x218 read back what was last written.
- R8: In the base variant, the extended-only offsets read 0 and ignore writes, and the core-1 vector output keeps its reset value. Offset 0x11C reads 0 and is read-only.
- R9: Word offsets 0xFD0 to 0xFFC return fixed identification bytes, in address order: 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Reads of write-only offsets (0x004, 0x008, 0x108) and of unmapped offsets return 0. Writes to read-only offsets (0x000, the identification words, and 0x11C in the base variant) and to unmapped offsets change no state.
- R11: Each of the following raises `access_err` for exactly the cycle after that transfer: a read of a write-only offset, a write to a read-only offset, or any access to an unmapped offset. Accesses to valid offsets do not raise it.
- R12: A write byte lane whose `pstrb` bit is 0 is stored as zero. The write always updates the whole word.
- R13: Only `paddr[11:2]` is decoded. The low two address bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Write byte-lane enables |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| ver_strap | input | 32 | Version strap; the top nibble selects the variant |
| sw_reset_req | output | 1 | One-cycle system reset request |
| core_release | output | 2 | One-cycle per-core release pulses |
| core_vector | output | 64 | Per-core initial vector bases, core 0 in the low word |
| access_err | output | 1 | One-cycle flag for an illegal access |

## Verification
Three kinds of behaviour are only visible one cycle after a transfer and show nothing on `prdata`: the release pulses, the reset request and the error flag. The bench therefore samples those pins in the cycle right after each write commits, and again one cycle later to confirm that each pulse has ended. Release pulses need a hold bit that is already 1, so the stimulus first sets both bits, then clears them one at a time, then clears both together, and finally pairs the clear with upper bits that must be stored without causing a pulse. The variant dependence needs the same offsets exercised under two straps with a reset between them, so that hidden words such as the 0x7F power-sense value are read as zero in one run and as their real contents in the other.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int NUM_CORES = 2;
  localparam int NUM_PLAIN = 15;
  localparam int SWREQ_BIT = 9;
  localparam int ID_WORDS  = 12;
  localparam logic [9:0] ID_BASE_WORD = 10'd1012;

  // Plain storage words come first so their enum value is their slot index.
  typedef enum logic [4:0] {
    RID_SECCTL   = 5'd0,
    RID_DIV0     = 5'd1,
    RID_DIV1     = 5'd2,
    RID_CLKFRC   = 5'd3,
    RID_SYNDROME = 5'd4,
    RID_RMASK    = 5'd5,
    RID_RETAIN   = 5'd6,
    RID_NMI      = 5'd7,
    RID_WAKE     = 5'd8,
    RID_EWAKE    = 5'd9,
    RID_PS_SYS   = 5'd10,
    RID_PS_M0    = 5'd11,
    RID_PS_M1    = 5'd12,
    RID_PS_M2    = 5'd13,
    RID_PS_M3    = 5'd14,
    RID_DBG_STAT = 5'd15,
    RID_DBG_SET  = 5'd16,
    RID_DBG_CLR  = 5'd17,
    RID_SWRST    = 5'd18,
    RID_VEC0     = 5'd19,
    RID_VEC1     = 5'd20,
    RID_HOLD     = 5'd21,
    RID_IDW      = 5'd22,
    RID_NONE     = 5'd23
  } reg_id_e;

  function automatic logic [31:0] plain_reset(input int slot);
    logic [31:0] v;
    v = 32'h0;
    if (slot == int'(RID_SYNDROME)) v = 32'h1;
    if (slot == int'(RID_PS_SYS))   v = 32'h7F;
    return v;
  endfunction

  function automatic logic [7:0] id_byte(input logic [3:0] k);
    logic [7:0] b;
    case (k)
      4'd0:  b = 8'h04;
      4'd4:  b = 8'h54;
      4'd5:  b = 8'hB8;
      4'd6:  b = 8'h0B;
      4'd8:  b = 8'h0D;
      4'd9:  b = 8'hF0;
      4'd10: b = 8'h05;
      4'd11: b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
  import sysctl_pkg::*;
(
  input  logic [9:0] waddr,
  input  logic       ext_en,
  output reg_id_e    rid,
  output logic       rd_ok,
  output logic       wr_ok,
  output logic [3:0] id_idx
);

  logic ext_only;

  always_comb begin
    rid      = RID_NONE;
    ext_only = 1'b0;
    id_idx   = 4'd0;
    case (waddr)
      10'h000: rid = RID_DBG_STAT;
      10'h001: rid = RID_DBG_SET;
      10'h002: rid = RID_DBG_CLR;
      10'h003: begin rid = RID_SECCTL;   ext_only = 1'b1; end
      10'h004: begin rid = RID_DIV0;     ext_only = 1'b1; end
      10'h005: begin rid = RID_DIV1;     ext_only = 1'b1; end
      10'h006: begin rid = RID_CLKFRC;   ext_only = 1'b1; end
      10'h040: rid = RID_SYNDROME;
      10'h041: rid = RID_RMASK;
      10'h042: rid = RID_SWRST;
      10'h043: rid = RID_RETAIN;
      10'h044: rid = RID_VEC0;
      10'h045: begin rid = RID_VEC1;     ext_only = 1'b1; end
      10'h046: rid = RID_HOLD;
      10'h047: rid = RID_NMI;
      10'h048: rid = RID_WAKE;
      10'h049: begin rid = RID_EWAKE;    ext_only = 1'b1; end
      10'h080: begin rid = RID_PS_SYS;   ext_only = 1'b1; end
      10'h083: begin rid = RID_PS_M0;    ext_only = 1'b1; end
      10'h084: begin rid = RID_PS_M1;    ext_only = 1'b1; end
      10'h085: begin rid = RID_PS_M2;    ext_only = 1'b1; end
      10'h086: begin rid = RID_PS_M3;    ext_only = 1'b1; end
      default: begin
        if (waddr >= ID_BASE_WORD) begin
          rid    = RID_IDW;
          id_idx = 4'(waddr - ID_BASE_WORD);
        end
      end
    endcase
    if (ext_only && !ext_en) rid = RID_NONE;
    rd_ok = !(rid inside {RID_DBG_SET, RID_DBG_CLR, RID_SWRST, RID_NONE});
    wr_ok = !(rid inside {RID_DBG_STAT, RID_IDW, RID_NONE}) &&
            !(rid == RID_NMI && !ext_en);
  end

endmodule

// File: rtl/sysctl_word_reg.sv
module sysctl_word_reg #(
  parameter int           W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= d;
  end

  // R10: a stored word moves only on its own write strobe
  a_r10_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/sysctl_core_ctl.sv
module sysctl_core_ctl #(
  parameter int           W        = 32,
  parameter int           NC       = 2,
  parameter logic [W-1:0] VEC_RST  = '0,
  parameter logic [W-1:0] HOLD_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NC-1:0]   vec_we,
  input  logic            hold_we,
  input  logic [W-1:0]    wdata,
  output logic [NC*W-1:0] vec_flat,
  output logic [W-1:0]    hold_q,
  output logic [NC-1:0]   release_o
);

  for (genvar c = 0; c < NC; c++) begin : g_core
    sysctl_word_reg #(.W(W), .RST(VEC_RST)) u_vec (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (vec_we[c]),
      .d    (wdata),
      .q    (vec_flat[c*W +: W])
    );

    // R6: the output carries exactly the written word from the next cycle
    a_r6_vector_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
      vec_we[c] |=> (vec_flat[c*W +: W] == $past(wdata)));

    // R5: a release pulse coincides with a 1 -> 0 step of the hold bit, both ways
    a_r5_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      release_o[c] |-> ($past(hold_q[c]) && !hold_q[c]));
    a_r5_fall_gives_release: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(hold_q[c]) && !hold_q[c]) |-> release_o[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= HOLD_RST;
      release_o <= '0;
    end else begin
      release_o <= hold_we ? (hold_q[NC-1:0] & ~wdata[NC-1:0]) : '0;
      if (hold_we) hold_q <= wdata;
    end
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] VEC_RST  = 32'h1000_0000,
  parameter logic [DATA_W-1:0] HOLD_RST = '0,
  parameter logic [3:0]        EXT_CODE = 4'h2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          psel,
  input  logic                          penable,
  input  logic                          pwrite,
  input  logic [ADDR_W-1:0]             paddr,
  input  logic [DATA_W-1:0]             pwdata,
  input  logic [DATA_W/8-1:0]           pstrb,
  output logic [DATA_W-1:0]             prdata,
  output logic                          pready,
  output logic                          pslverr,
  input  logic [DATA_W-1:0]             ver_strap,
  output logic                          sw_reset_req,
  output logic [NUM_CORES-1:0]          core_release,
  output logic [NUM_CORES*DATA_W-1:0]   core_vector,
  output logic                          access_err
);

  localparam int STRB_W  = DATA_W / 8;
  localparam int WORD_AW = ADDR_W - 2;

  logic              access, wr_en, rd_en, ext_en;
  logic [DATA_W-1:0] wdata_eff;
  logic [DATA_W-1:0] dbg_q, hold_q, rdata;
  logic [DATA_W-1:0] plain_q [NUM_PLAIN];
  reg_id_e           rid;
  logic              rd_ok, wr_ok;
  logic [3:0]        id_idx;
  logic              sig_unused;

  assign access  = psel && penable;
  assign wr_en   = access && pwrite;
  assign rd_en   = access && !pwrite;
  assign ext_en  = (ver_strap[DATA_W-1 -: 4] == EXT_CODE);
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign sig_unused = ^{paddr[1:0], ver_strap[DATA_W-5:0]};

  // Byte lanes without a strobe are taken as zero; the word is written whole.
  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    assign wdata_eff[b*8 +: 8] = pstrb[b] ? pwdata[b*8 +: 8] : 8'h00;
  end

  sysctl_addr_dec u_dec (
    .waddr (paddr[ADDR_W-1 -: WORD_AW]),
    .ext_en(ext_en),
    .rid   (rid),
    .rd_ok (rd_ok),
    .wr_ok (wr_ok),
    .id_idx(id_idx)
  );

  for (genvar s = 0; s < NUM_PLAIN; s++) begin : g_plain
    localparam logic [DATA_W-1:0] RV = DATA_W'(plain_reset(s));
    sysctl_word_reg #(.W(DATA_W), .RST(RV)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (wr_en && wr_ok && (rid == reg_id_e'(s))),
      .d    (wdata_eff),
      .q    (plain_q[s])
    );
  end

  sysctl_core_ctl #(
    .W(DATA_W), .NC(NUM_CORES), .VEC_RST(VEC_RST), .HOLD_RST(HOLD_RST)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .vec_we   ({wr_en && rid == RID_VEC1, wr_en && rid == RID_VEC0}),
    .hold_we  (wr_en && rid == RID_HOLD),
    .wdata    (wdata_eff),
    .vec_flat (core_vector),
    .hold_q   (hold_q),
    .release_o(core_release)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q        <= '0;
      sw_reset_req <= 1'b0;
      access_err   <= 1'b0;
    end else begin
      if (wr_en && rid == RID_DBG_SET)      dbg_q <= dbg_q | wdata_eff;
      else if (wr_en && rid == RID_DBG_CLR) dbg_q <= dbg_q & ~wdata_eff;
      sw_reset_req <= wr_en && (rid == RID_SWRST) && wdata_eff[SWREQ_BIT];
      access_err   <= access && (pwrite ? !wr_ok : !rd_ok);
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en && rd_ok) begin
      case (rid)
        RID_DBG_STAT: rdata = dbg_q;
        RID_VEC0:     rdata = core_vector[0 +: DATA_W];
        RID_VEC1:     rdata = core_vector[DATA_W +: DATA_W];
        RID_HOLD:     rdata = hold_q;
        RID_IDW:      rdata = DATA_W'(id_byte(id_idx));
        default: begin
          for (int s = 0; s < NUM_PLAIN; s++)
            if (rid == reg_id_e'(s)) rdata = plain_q[s];
        end
      endcase
    end
  end
  assign prdata = rdata;

  // R3: set alias lands every written 1; clear alias removes every written 1
  a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rid == RID_DBG_SET) |=> ((dbg_q & $past(wdata_eff)) == $past(wdata_eff)));
  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rid == RID_DBG_CLR) |=> ((dbg_q & $past(wdata_eff)) == '0));

  // R4: a reset request only ever follows a write to the reset word
  a_r4_req_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_req |-> $past(wr_en && rid == RID_SWRST));

  // R11: any access to an unmapped offset is flagged in the next cycle
  a_r11_unmapped_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (access && rid == RID_NONE) |=> access_err);

endmodule

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0]  pstrb = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [31:0] ver_strap = 32'h1000_0000;
  logic        sw_reset_req;
  logic [1:0]  core_release;
  logic [63:0] core_vector;
  logic        access_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .ver_strap(ver_strap),
    .sw_reset_req(sw_reset_req), .core_release(core_release),
    .core_vector(core_vector), .access_err(access_err)
  );

  task automatic chk(input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // Monitor: every access phase is checked for R1; reads are compared
  // against the scoreboard queue filled by the driver.
  always @(negedge clk) begin
    if (psel && penable) begin
      chk(pready && !pslverr, "R1 zero-wait OKAY", {pready, pslverr}, 2'b10);
      if (!pwrite) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected read", prdata, 0);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(prdata == e, t, prdata, e);
        end
      end
    end
  end

  task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [3:0] s, input bit exp_err, input string tag);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    chk(access_err == exp_err, {"R11 error flag after ", tag}, access_err, exp_err);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e,
                    input bit exp_err, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    apb(1'b0, a, 32'h0, 4'h0, exp_err, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input bit exp_err, input string tag);
    apb(1'b1, a, d, 4'hF, exp_err, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic next_cycle();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] id_tab [12];
    logic [11:0] ext_addr [11];
    id_tab = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8,
               8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    ext_addr = '{12'h00C, 12'h010, 12'h014, 12'h018, 12'h124, 12'h200,
                 12'h20C, 12'h210, 12'h214, 12'h218, 12'h11C};

    // ---------------- base variant ----------------
    ver_strap = 32'h1000_0000;
    do_reset();
    chk(core_vector == {32'h1000_0000, 32'h1000_0000}, "R2 vector outputs at reset",
        core_vector, {32'h1000_0000, 32'h1000_0000});
    chk({sw_reset_req, core_release, access_err} == 4'b0, "R2 pulses idle at reset",
        {sw_reset_req, core_release, access_err}, 0);
    rd(12'h100, 32'h1, 0, "R2 reset-cause word");
    rd(12'h000, 32'h0, 0, "R2 debug status");
    rd(12'h110, 32'h1000_0000, 0, "R2 core0 vector");
    rd(12'h118, 32'h0, 0, "R2 hold word");
    rd(12'h10C, 32'h0, 0, "R2 retention word");
    rd(12'h104, 32'h0, 0, "R2 reset mask");
    rd(12'h120, 32'h0, 0, "R2 wake control");

    for (int k = 0; k < 12; k++)
      rd(12'(12'hFD0 + 4 * k), {24'h0, id_tab[k]}, 0, "R9 identification word");
    wr(12'hFE0, 32'hFFFF_FFFF, 1, "R10 write to id word");
    rd(12'hFE0, 32'h54, 0, "R10 id word unchanged");

    wr(12'h010, 32'h1234, 1, "R8 base write divider");
    rd(12'h010, 32'h0, 1, "R8 base divider reads zero");
    rd(12'h200, 32'h0, 1, "R8 base power-sense hidden");
    wr(12'h114, 32'h2000_0000, 1, "R8 base write core1 vector");
    rd(12'h114, 32'h0, 1, "R8 base core1 vector hidden");
    chk(core_vector[63:32] == 32'h1000_0000, "R8 core1 output unchanged",
        core_vector[63:32], 32'h1000_0000);
    wr(12'h11C, 32'h1, 1, "R8 base write read-only 0x11C");
    rd(12'h11C, 32'h0, 0, "R8 base 0x11C reads zero");

    rd(12'h004, 32'h0, 1, "R10 read set alias");
    rd(12'h008, 32'h0, 1, "R10 read clear alias");
    rd(12'h300, 32'h0, 1, "R10 read unmapped");
    wr(12'h000, 32'hFF, 1, "R10 write status word");
    rd(12'h000, 32'h0, 0, "R10 status unchanged");
    wr(12'h400, 32'hFFFF_FFFF, 1, "R11 write unmapped");
    next_cycle();
    chk(access_err == 1'b0, "R11 flag lasts one cycle", access_err, 0);

    wr(12'h004, 32'hF0, 0, "R3 set alias");
    rd(12'h000, 32'hF0, 0, "R3 status after set");
    wr(12'h004, 32'h0F, 0, "R3 set alias again");
    rd(12'h000, 32'hFF, 0, "R3 status OR accumulates");
    wr(12'h008, 32'h3C, 0, "R3 clear alias");
    rd(12'h000, 32'hC3, 0, "R3 status after clear");
    wr(12'h008, 32'h0, 0, "R3 clear with zeros");
    rd(12'h000, 32'hC3, 0, "R3 zeros clear nothing");

    wr(12'h108, 32'h200, 0, "R4 reset request");
    chk(sw_reset_req == 1'b1, "R4 request pulse", sw_reset_req, 1);
    next_cycle();
    chk(sw_reset_req == 1'b0, "R4 request lasts one cycle", sw_reset_req, 0);
    wr(12'h108, 32'hFFFF_FDFF, 0, "R4 other bits");
    chk(sw_reset_req == 1'b0, "R4 other bits raise nothing", sw_reset_req, 0);
    rd(12'h108, 32'h0, 1, "R4 reset word reads zero");

    wr(12'h118, 32'h3, 0, "R5 hold both");
    chk(core_release == 2'b00, "R5 no release on rise", core_release, 0);
    rd(12'h118, 32'h3, 0, "R5 hold readback");
    wr(12'h118, 32'h1, 0, "R5 free core1");
    chk(core_release == 2'b10, "R5 core1 release", core_release, 2'b10);
    next_cycle();
    chk(core_release == 2'b00, "R5 release one cycle", core_release, 0);
    wr(12'h118, 32'h0, 0, "R5 free core0");
    chk(core_release == 2'b01, "R5 core0 release", core_release, 2'b01);
    wr(12'h118, 32'hF0F0_0003, 0, "R5 hold with upper bits");
    chk(core_release == 2'b00, "R5 no release on set", core_release, 0);
    rd(12'h118, 32'hF0F0_0003, 0, "R5 full value stored");
    wr(12'h118, 32'hF0F0_0000, 0, "R5 free both");
    chk(core_release == 2'b11, "R5 both release", core_release, 2'b11);
    rd(12'h118, 32'hF0F0_0000, 0, "R5 full value after release");

    wr(12'h110, 32'h0800_0100, 0, "R6 core0 vector write");
    chk(core_vector[31:0] == 32'h0800_0100, "R6 core0 vector output",
        core_vector[31:0], 32'h0800_0100);
    rd(12'h110, 32'h0800_0100, 0, "R6 core0 vector readback");

    apb(1'b1, 12'h10C, 32'hAABB_CCDD, 4'b0010, 0, "R12 single lane");
    rd(12'h10C, 32'h0000_CC00, 0, "R12 unstrobed lanes zero");
    apb(1'b1, 12'h10C, 32'hAABB_CCDD, 4'b1001, 0, "R12 outer lanes");
    rd(12'h10C, 32'hAA00_00DD, 0, "R12 outer lanes kept");

    wr(12'h10E, 32'h5A5A_5A5A, 0, "R13 unaligned write");
    rd(12'h10D, 32'h5A5A_5A5A, 0, "R13 low address bits ignored");

    // ---------------- extended variant ----------------
    ver_strap = 32'h2000_0001;
    do_reset();
    rd(12'h200, 32'h7F, 0, "R2 system power-sense reset");
    rd(12'h114, 32'h1000_0000, 0, "R2 core1 vector reset");
    rd(12'h010, 32'h0, 0, "R2 divider reset");
    for (int k = 0; k < 11; k++)
      wr(ext_addr[k], 32'hA500_0000 | 32'(k), 0, "R7 extended write");
    for (int k = 0; k < 11; k++)
      rd(ext_addr[k], 32'hA500_0000 | 32'(k), 0, "R7 extended readback");
    wr(12'h114, 32'h3000_0000, 0, "R7 core1 vector write");
    chk(core_vector[63:32] == 32'h3000_0000, "R6 core1 vector output",
        core_vector[63:32], 32'h3000_0000);
    rd(12'h114, 32'h3000_0000, 0, "R7 core1 vector readback");

    next_cycle();
    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule